// File: doc/BRIEF.md
# Late-write register-latch synchronous SRAM

This block is a synthesizable model of a single-port synchronous static RAM. Its data bus is shared in both directions and is modelled as three signals: a write-data input, a read-data output and an output enable. Address and command are taken on the rising clock edge. Read data is driven from the falling edge of that same cycle, half a cycle later. Write data follows its address by one full cycle. It waits in a one-deep write buffer, together with its address and byte mask, and goes into the array only when the next write is accepted.

Every rising edge moves a small state register to one of five states. The choice depends only on the inputs sampled at that edge: `ST_SLEEP` when sleep is high, otherwise `ST_IDLE` for a deselect, `ST_READ` for a read, `ST_ABORT` for a write with every byte enable inactive, and `ST_WRITE` for any other write. The next edge may take the register from any state to any state. `ST_READ` loads the falling-edge output latch. `ST_WRITE` takes the data word into the buffer and commits the word the buffer held before. The other three states change neither the buffer nor the array. A read whose address matches the buffer takes the buffered bytes and fills the remaining bytes from the array.

Top module: `lw_rl_sram`

## Requirements
- R1: A cycle sampled with `sel_n` high is a deselect. From the falling edge of that cycle until the next falling edge, `doe` is low.
- R2: A cycle sampled with `sel_n` low and `we_n` high is a read. From the falling edge of that cycle until the next falling edge, `doe` is high and `dout` holds the word at `addr`.
- R3: The write data for a write command is the value on `din` at the rising edge one cycle after the command edge. The value on `din` during the command cycle is ignored.
- R4: A write with every bit of `bw_n` low stores all bytes of the word.
- R5: A write with only some bits of `bw_n` low stores only those bytes. Bit i of `bw_n` covers data bits 9*i+8 down to 9*i. The other bytes keep their old values.
- R6: A write with every bit of `bw_n` high is an abort. It stores no byte and leaves a pending buffered write untouched.
- R7: A buffered write stays pending through reads, deselects, aborts and sleep cycles. It goes into the array when the next write command's data is taken.
- R8: A read of the buffered address returns the buffered bytes merged over the array bytes, including a read in the very next cycle after the write.
- R9: While `sleep` is high, `doe` is forced low at once, with no wait for a clock edge. Commands sampled while `sleep` is high act as deselects, and the stored contents are kept.
- R10: An active-low `rst_n` drives `doe` low and empties the write buffer, so a pending write is dropped. It does not clear the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Commands are sampled on the rising edge and read data is launched on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Asynchronous power-down request. Forces the bus to high impedance |
| sel_n | input | 1 | Active-low select. High means deselect |
| we_n | input | 1 | Active-low write enable. High means read |
| bw_n | input | W/9 | Active-low byte write enables, one for each 9-bit byte |
| addr | input | AW | Word address |
| din | input | W | Write data, taken one cycle after its command |
| dout | output | W | Read data from the falling-edge latch |
| doe | output | 1 | Output enable. Low means the bus is high impedance |

## Verification
The main function is exercised with several command patterns. Back-to-back full writes followed by a run of reads show that each write is committed when the next write arrives and never lost. A read placed directly after a write to the same address, with random partial byte masks, checks the byte-wise merge of buffer and array. A read of that address after the buffer has moved on checks that the committed word matches. Aborts placed after a pending write, and writes placed during sleep, show that these commands change nothing. A reset between a write and the next write tells a pending word apart from a committed one, because the old array value comes back.

// File: rtl/lw_rl_sram_pkg.sv
package lw_rl_sram_pkg;

    localparam int BYTE_W = 9;

    // Command accepted at the most recent rising edge
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WRITE = 3'd2,
        ST_ABORT = 3'd3,
        ST_SLEEP = 3'd4
    } lw_state_e;

endpackage

// File: rtl/lw_rl_sram_ctrl.sv
module lw_rl_sram_ctrl
    import lw_rl_sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep,
    input  logic            sel_n,
    input  logic            we_n,
    input  logic [NB-1:0]   bw_n,
    input  logic [AW-1:0]   addr,
    output lw_state_e       st,
    output logic [AW-1:0]   cmd_addr,
    output logic [NB-1:0]   cmd_mask,
    output logic            rd_cycle,
    output logic            wdata_cycle
);

    lw_state_e st_nxt;

    // Next state depends only on the command sampled at this edge
    always_comb begin
        if (sleep) begin
            st_nxt = ST_SLEEP;
        end else if (sel_n) begin
            st_nxt = ST_IDLE;
        end else if (we_n) begin
            st_nxt = ST_READ;
        end else if (&bw_n) begin
            st_nxt = ST_ABORT;
        end else begin
            st_nxt = ST_WRITE;
        end
    end

    // State and command register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cmd_addr <= '0;
            cmd_mask <= '0;
        end else begin
            st <= st_nxt;
            if (st_nxt == ST_READ || st_nxt == ST_WRITE) begin
                cmd_addr <= addr;
                cmd_mask <= ~bw_n;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        rd_cycle    = 1'b0;
        wdata_cycle = 1'b0;
        unique case (st)
            ST_READ:  rd_cycle    = 1'b1;
            ST_WRITE: wdata_cycle = 1'b1;
            ST_IDLE, ST_ABORT, ST_SLEEP: begin
                rd_cycle    = 1'b0;
                wdata_cycle = 1'b0;
            end
            default: begin
                rd_cycle    = 1'b0;
                wdata_cycle = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lw_rl_sram_wbuf.sv
module lw_rl_sram_wbuf #(
    parameter int AW = 6,
    parameter int W  = 36,
    parameter int NB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [AW-1:0]   ld_addr,
    input  logic [NB-1:0]   ld_mask,
    input  logic [W-1:0]    din,
    output logic            wb_valid,
    output logic [AW-1:0]   wb_addr,
    output logic [W-1:0]    wb_data,
    output logic [NB-1:0]   wb_mask,
    output logic            commit_en
);

    // The previous entry goes to the array at the edge that loads a new one
    assign commit_en = load & wb_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_addr  <= '0;
            wb_data  <= '0;
            wb_mask  <= '0;
        end else if (load) begin
            wb_valid <= 1'b1;
            wb_addr  <= ld_addr;
            wb_data  <= din;
            wb_mask  <= ld_mask;
        end
    end

endmodule

// File: rtl/lw_rl_sram_array.sv
module lw_rl_sram_array #(
    parameter int AW = 6,
    parameter int W  = 36,
    parameter int NB = 4
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [W-1:0]    wr_data,
    input  logic [NB-1:0]   wr_mask,
    input  logic [AW-1:0]   rd_addr,
    output logic [W-1:0]    rd_data
);

    localparam int DEPTH = 1 << AW;
    localparam int LW    = W / NB;

    // One storage lane per byte, each with its own write enable
    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [LW-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[b]) begin
                lane_mem[wr_addr] <= wr_data[b*LW +: LW];
            end
        end

        assign rd_data[b*LW +: LW] = lane_mem[rd_addr];
    end

endmodule

// File: rtl/lw_rl_sram_outlat.sv
module lw_rl_sram_outlat #(
    parameter int AW = 6,
    parameter int W  = 36,
    parameter int NB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_cycle,
    input  logic [AW-1:0]   rd_addr,
    input  logic [W-1:0]    arr_data,
    input  logic            wb_valid,
    input  logic [AW-1:0]   wb_addr,
    input  logic [W-1:0]    wb_data,
    input  logic [NB-1:0]   wb_mask,
    output logic [W-1:0]    dout_q,
    output logic            doe_q
);

    localparam int LW = W / NB;

    logic          hit;
    logic [W-1:0]  merged;

    assign hit = wb_valid && (wb_addr == rd_addr);

    // Byte-wise bypass of the pending write
    for (genvar b = 0; b < NB; b++) begin : g_merge
        assign merged[b*LW +: LW] = (hit && wb_mask[b]) ? wb_data[b*LW +: LW]
                                                        : arr_data[b*LW +: LW];
    end

    // Output latch launched on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            doe_q  <= 1'b0;
            dout_q <= '0;
        end else begin
            doe_q <= rd_cycle;
            if (rd_cycle) begin
                dout_q <= merged;
            end
        end
    end

endmodule

// File: rtl/lw_rl_sram.sv
module lw_rl_sram
    import lw_rl_sram_pkg::*;
#(
    parameter int W  = 36,
    parameter int AW = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sleep,
    input  logic                  sel_n,
    input  logic                  we_n,
    input  logic [W/BYTE_W-1:0]   bw_n,
    input  logic [AW-1:0]         addr,
    input  logic [W-1:0]          din,
    output logic [W-1:0]          dout,
    output logic                  doe
);

    localparam int NB = W / BYTE_W;

    lw_state_e        st;
    logic [AW-1:0]    cmd_addr;
    logic [NB-1:0]    cmd_mask;
    logic             rd_cycle;
    logic             wdata_cycle;
    logic             wb_valid;
    logic [AW-1:0]    wb_addr;
    logic [W-1:0]     wb_data;
    logic [NB-1:0]    wb_mask;
    logic             commit_en;
    logic [W-1:0]     arr_data;
    logic [W-1:0]     dout_q;
    logic             doe_q;

    lw_rl_sram_ctrl #(.AW(AW), .NB(NB)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep       (sleep),
        .sel_n       (sel_n),
        .we_n        (we_n),
        .bw_n        (bw_n),
        .addr        (addr),
        .st          (st),
        .cmd_addr    (cmd_addr),
        .cmd_mask    (cmd_mask),
        .rd_cycle    (rd_cycle),
        .wdata_cycle (wdata_cycle)
    );

    lw_rl_sram_wbuf #(.AW(AW), .W(W), .NB(NB)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wdata_cycle),
        .ld_addr   (cmd_addr),
        .ld_mask   (cmd_mask),
        .din       (din),
        .wb_valid  (wb_valid),
        .wb_addr   (wb_addr),
        .wb_data   (wb_data),
        .wb_mask   (wb_mask),
        .commit_en (commit_en)
    );

    lw_rl_sram_array #(.AW(AW), .W(W), .NB(NB)) u_array (
        .clk     (clk),
        .wr_en   (commit_en),
        .wr_addr (wb_addr),
        .wr_data (wb_data),
        .wr_mask (wb_mask),
        .rd_addr (cmd_addr),
        .rd_data (arr_data)
    );

    lw_rl_sram_outlat #(.AW(AW), .W(W), .NB(NB)) u_outlat (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_cycle (rd_cycle),
        .rd_addr  (cmd_addr),
        .arr_data (arr_data),
        .wb_valid (wb_valid),
        .wb_addr  (wb_addr),
        .wb_data  (wb_data),
        .wb_mask  (wb_mask),
        .dout_q   (dout_q),
        .doe_q    (doe_q)
    );

    // Sleep gates the driver without waiting for a clock edge
    assign doe  = doe_q & ~sleep;
    assign dout = dout_q;

endmodule

// File: rtl/lw_rl_sram_chk.sv
module lw_rl_sram_chk
    import lw_rl_sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int W  = 36,
    parameter int NB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep,
    input  logic            sel_n,
    input  logic            we_n,
    input  logic [NB-1:0]   bw_n,
    input  logic            doe,
    input  lw_state_e       st,
    input  logic            wb_valid,
    input  logic [AW-1:0]   wb_addr,
    input  logic [W-1:0]    wb_data,
    input  logic [NB-1:0]   wb_mask
);

    a_r1_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && !sleep) |=> !doe);

    a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && we_n && !sleep) |=> (doe || sleep));

    a_r6_abort_keeps_buf: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !we_n && (&bw_n) && !sleep) |-> ##2
        ($stable(wb_valid) && $stable(wb_data) && $stable(wb_addr)));

    a_r7_buf_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_WRITE) |=>
        ($stable(wb_data) && $stable(wb_addr) && $stable(wb_mask)));

    a_r9_sleep_hiz: assert property (@(negedge clk) disable iff (!rst_n)
        sleep |-> !doe);

endmodule

bind lw_rl_sram lw_rl_sram_chk #(.AW(AW), .W(W), .NB(NB)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .sel_n    (sel_n),
    .we_n     (we_n),
    .bw_n     (bw_n),
    .doe      (doe),
    .st       (st),
    .wb_valid (wb_valid),
    .wb_addr  (wb_addr),
    .wb_data  (wb_data),
    .wb_mask  (wb_mask)
);

// File: tb/lw_rl_sram_tb.sv
module lw_rl_sram_tb;

    localparam int W     = 36;
    localparam int AW    = 6;
    localparam int NB    = W / 9;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           sleep = 1'b0;
    logic           sel_n = 1'b1;
    logic           we_n  = 1'b1;
    logic [NB-1:0]  bw_n  = '1;
    logic [AW-1:0]  addr  = '0;
    logic [W-1:0]   din   = '0;
    logic [W-1:0]   dout;
    logic           doe;

    lw_rl_sram #(.W(W), .AW(AW)) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .sleep (sleep),
        .sel_n (sel_n),
        .we_n  (we_n),
        .bw_n  (bw_n),
        .addr  (addr),
        .din   (din),
        .dout  (dout),
        .doe   (doe)
    );

    typedef struct {
        logic          oe;
        logic [W-1:0]  data;
        string         req;
    } exp_t;

    exp_t          q[$];
    logic [W-1:0]  gold [DEPTH];
    logic [W-1:0]  pend_data = '0;
    logic          rst_next   = 1'b0;
    logic          sleep_next = 1'b0;
    int            checks = 0;
    int            fails  = 0;
    bit            done   = 0;

    localparam logic [W-1:0] GARBAGE = {NB{9'h1A5}};

    // Driver: one command per call, applied after the falling edge
    task automatic cmd(input logic s_n, input logic w_n, input logic [NB-1:0] b,
                       input logic [AW-1:0] a, input logic [W-1:0] wd, input string req);
        exp_t e;
        @(negedge clk);
        #2;
        rst_n = rst_next;
        sleep = sleep_next;
        din   = pend_data;
        sel_n = s_n;
        we_n  = w_n;
        bw_n  = b;
        addr  = a;
        e.oe   = 1'b0;
        e.data = '0;
        e.req  = req;
        if (!sleep && rst_n) begin
            if (!s_n && w_n) begin
                e.oe   = 1'b1;
                e.data = gold[a];
            end else if (!s_n && !w_n) begin
                for (int i = 0; i < NB; i++) begin
                    if (!b[i]) gold[a][i*9 +: 9] = wd[i*9 +: 9];
                end
            end
        end
        pend_data = (!s_n && !w_n) ? wd : GARBAGE;
        q.push_back(e);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [NB-1:0] b,
                      input logic [W-1:0] wd, input string req);
        cmd(1'b0, 1'b0, b, a, wd, req);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string req);
        cmd(1'b0, 1'b1, '1, a, '0, req);
    endtask

    task automatic idle(input string req);
        cmd(1'b1, 1'b1, '1, '0, '0, req);
    endtask

    function automatic logic [W-1:0] rnd_word();
        return W'({$urandom, $urandom});
    endfunction

    // Monitor: compares each cycle's bus state just after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (doe !== e.oe) begin
                    fails++;
                    $display("FAIL %s doe act=%b exp=%b", e.req, doe, e.oe);
                end else if (e.oe && dout !== e.data) begin
                    fails++;
                    $display("FAIL %s dout act=%h exp=%h", e.req, dout, e.data);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v1;
        for (int i = 0; i < DEPTH; i++) gold[i] = '0;

        // R10: bus quiet while reset is held
        rst_next = 1'b0;
        rd(6'd0, "R10");
        rd(6'd1, "R10");
        rst_next = 1'b1;
        idle("R10");

        // R4 / R7: back-to-back full writes, each committed by the next
        for (int i = 0; i < 8; i++) wr(AW'(i), '0, rnd_word(), "R4");
        for (int i = 0; i < 8; i++) rd(AW'(i), "R4");

        // R1 / R2: reads interleaved with deselects
        rd(6'd3, "R2");
        idle("R1");
        idle("R1");
        rd(6'd5, "R2");
        idle("R1");

        // R5 / R8: partial writes read back at once and after commit
        wr(6'd2, 4'b1010, rnd_word(), "R5");
        rd(6'd2, "R8");
        wr(6'd3, 4'b0111, rnd_word(), "R5");
        rd(6'd3, "R8");
        rd(6'd2, "R5");
        idle("R1");
        rd(6'd3, "R5");

        // R6: abort alone and abort after a pending write
        wr(6'd4, '1, rnd_word(), "R6");
        rd(6'd4, "R6");
        wr(6'd5, '0, rnd_word(), "R6");
        wr(6'd5, '1, rnd_word(), "R6");
        rd(6'd5, "R6");

        // R7: pending write survives reads and deselects
        wr(6'd6, 4'b1100, rnd_word(), "R7");
        idle("R7");
        rd(6'd1, "R7");
        idle("R7");
        rd(6'd6, "R7");

        // R3: data taken a cycle after the command (command-cycle din is garbage)
        wr(6'd9, '0, rnd_word(), "R3");
        idle("R3");
        rd(6'd9, "R3");

        // R8 / R5: random masks, read right after the write, then after commit
        for (int i = 0; i < 24; i++) begin
            logic [AW-1:0] a;
            a = AW'($urandom_range(0, 7));
            wr(a, NB'($urandom), rnd_word(), "R5");
            rd(a, "R8");
        end
        for (int i = 0; i < 8; i++) rd(AW'(i), "R8");

        // R9: asynchronous sleep and ignored commands
        rd(6'd2, "R9");
        sleep_next = 1'b1;
        idle("R9");
        #1;
        checks++;
        if (doe !== 1'b0) begin
            fails++;
            $display("FAIL R9 async doe act=%b exp=0", doe);
        end
        wr(6'd2, '0, rnd_word(), "R9");
        idle("R9");
        rd(6'd2, "R9");
        sleep_next = 1'b0;
        idle("R9");
        rd(6'd2, "R9");
        rd(6'd7, "R9");

        // R10 / R7: reset drops a pending write but keeps the array
        v1 = rnd_word();
        wr(6'd12, '0, v1, "R7");
        wr(6'd13, '0, rnd_word(), "R7");
        wr(6'd12, '0, rnd_word(), "R7");
        rd(6'd12, "R8");
        rst_next = 1'b0;
        idle("R10");
        idle("R10");
        rst_next = 1'b1;
        gold[12] = v1;
        idle("R10");
        rd(6'd12, "R10");
        rd(6'd13, "R10");
        wr(6'd14, 4'b0000, rnd_word(), "R4");
        rd(6'd14, "R8");
        idle("R1");
        idle("R1");
        idle("R1");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule